// File: doc/BRIEF.md
# Per-Channel Train Event Buffer

This block keeps the triggered events of one calorimeter readout channel for the length of a bunch train. When a train starts, a bunch-crossing timestamp counter is zeroed and the channel becomes active. Each accepted trigger latches the current timestamp and then waits for one converted sample from the digitizer. The digitizer is seen as a ready/valid source. The sample is a 13-bit amplitude with a 1-bit gain-range flag. Amplitude, range flag and timestamp go into the next free slot of a four-slot buffer.

A configuration bit picks the trigger source: the channel's own self-trigger discriminator or a shared external trigger. Triggers that arrive when all slots are full are dropped, and a sticky overflow flag records that. When the train ends, the channel streams out a header word carrying the slot count and the overflow flag. It then streams the stored events from oldest to newest over a valid/ready port. When the last word is taken the buffer is empty again.

The control is a five-state machine:
- `ST_IDLE` has no train. A train start moves to `ST_ACTIVE`.
- `ST_ACTIVE` takes triggers. A train start in this state clears the buffer and stays in `ST_ACTIVE`. A trigger with a free slot moves to `ST_WAIT`. A train end moves to `ST_HEAD`.
- `ST_WAIT` holds sample-ready high. A sample moves back to `ST_ACTIVE`, or to `ST_HEAD` if a train end was seen.
- `ST_HEAD` presents the header. If it is taken with no events stored, the machine goes to `ST_IDLE`; otherwise it goes to `ST_DATA`.
- `ST_DATA` presents each event in turn. Taking the final word moves to `ST_IDLE`.

Top module: `train_event_buffer`

## Requirements
- R1: After reset `ro_valid`, `ro_last` and `smp_ready` are low and no train is in progress.
- R2: A `train_start` pulse clears all slots and the overflow flag and zeroes the timestamp. It is honoured only when no train is running or during the active phase; during readout it has no effect on the stream.
- R3: With `trig_mode` = 0 only `self_hit` triggers; with `trig_mode` = 1 only `ext_trig` triggers. The unselected input is ignored.
- R4: An accepted trigger in the active phase, with a slot free, raises `smp_ready` in the next cycle. `smp_ready` stays high until a cycle with `smp_valid` high. That sample's amplitude and range flag are stored with the trigger's timestamp, and `smp_ready` is low in the cycle after.
- R5: Triggers are discarded while a sample is awaited, while no train is running, and during readout.
- R6: A trigger when all 4 slots are full is not stored and sets a sticky overflow flag.
- R7: The stored timestamp is the number of clock edges from the edge that accepted `train_start` to the edge before the one that samples the trigger. The counter wraps modulo 2^13.
- R8: After `train_end` the port emits a header `{overflow at bit 3, count at bits 2:0}` zero-extended to 27 bits. It then emits each stored event, oldest first, as `{timestamp[26:14], range[13], amplitude[12:0]}`. `ro_last` is high on the final word; with no events that is the header.
- R9: While `ro_valid` is high and `ro_ready` is low, `ro_valid` and `ro_data` hold.
- R10: A trigger and `train_end` in the same cycle resolve as trigger first. Readout waits, with `ro_valid` low, until the sample is stored, and that event is included.
- R11: After the final word is taken the block returns to idle with the buffer empty. A `train_end` while idle produces no readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_mode | input | 1 | Trigger source select: 0 self-trigger, 1 external |
| self_hit | input | 1 | Self-trigger discriminator output |
| ext_trig | input | 1 | External trigger |
| train_start | input | 1 | Train start pulse |
| train_end | input | 1 | End of active train pulse |
| smp_valid | input | 1 | Converter sample valid |
| smp_ready | output | 1 | Block waits for a sample |
| smp_amp | input | 13 | Converter amplitude |
| smp_range | input | 1 | Selected gain range flag |
| ro_valid | output | 1 | Readout word valid |
| ro_ready | input | 1 | Readout consumer ready |
| ro_data | output | 27 | Readout word (header or event) |
| ro_last | output | 1 | Final word of this train's readout |

## Verification
The hardest situation to reach from the ports is a trigger coinciding with `train_end`. The bench drives both in the same cycle and delays the converter's response by several cycles. During that delay it checks that no readout starts, then expects the late event in the stream. Overflow is reached by firing five triggers in one train, with a stray trigger placed inside one sample wait. The readout consumer then stalls irregularly while a `train_start` and a trigger are pulsed into the running stream, which must continue unchanged. A long idle train of more than 8192 cycles forces the timestamp to wrap before a trigger.

// File: rtl/tebuf_pkg.sv
package tebuf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACTIVE,
        ST_WAIT,
        ST_HEAD,
        ST_DATA
    } state_t;
endpackage

// File: rtl/tebuf_tstamp.sv
module tebuf_tstamp #(
    parameter int TS_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            run,
    output logic [TS_W-1:0] ts
);
    logic [TS_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + TS_W'(1);
    end

    assign ts = cnt_q;

    // R7
    ts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ts == '0));
endmodule

// File: rtl/tebuf_slots.sv
module tebuf_slots #(
    parameter int SLOTS  = 4,
    parameter int WORD_W = 27,
    parameter int CNT_W  = 3,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              full
);
    logic [WORD_W-1:0] slot_q [SLOTS];
    logic [CNT_W-1:0]  cnt_q;

    assign full  = (cnt_q == CNT_W'(SLOTS));
    assign count = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (wr_en && !full)
            cnt_q <= cnt_q + CNT_W'(1);
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && !full && (cnt_q == CNT_W'(g)))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SLOTS));

    // R6
    no_wr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
endmodule

// File: rtl/tebuf_ctrl.sv
module tebuf_ctrl
    import tebuf_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int TS_W   = 13,
    parameter int AMP_W  = 13,
    parameter int CNT_W  = 3,
    parameter int IDX_W  = 2,
    parameter int WORD_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_start,
    input  logic              train_end,
    input  logic              trig,
    input  logic              smp_valid,
    input  logic [AMP_W-1:0]  smp_amp,
    input  logic              smp_range,
    input  logic              ro_ready,
    input  logic [TS_W-1:0]   ts,
    input  logic [CNT_W-1:0]  count,
    input  logic              full,
    input  logic [WORD_W-1:0] rd_data,
    output logic              smp_ready,
    output logic              ro_valid,
    output logic [WORD_W-1:0] ro_data,
    output logic              ro_last,
    output logic              slot_clr,
    output logic              slot_wr,
    output logic [WORD_W-1:0] slot_wdata,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              ts_clr,
    output logic              ts_run
);
    state_t            st_q, st_d;
    logic              ovf_q, end_pend_q;
    logic [TS_W-1:0]   ts_hold_q;
    logic [IDX_W-1:0]  idx_q;
    logic              start_ok, take_trig, drop_trig, wr_now, last_word, ro_done;

    always_comb begin
        start_ok  = train_start && (st_q == ST_IDLE || st_q == ST_ACTIVE);
        take_trig = (st_q == ST_ACTIVE) && !train_start && trig && !full;
        drop_trig = (st_q == ST_ACTIVE) && !train_start && trig && full;
        wr_now    = (st_q == ST_WAIT) && smp_valid;
        if (st_q == ST_HEAD)
            last_word = (count == '0);
        else
            last_word = ((CNT_W'(idx_q) + CNT_W'(1)) == count);
        ro_done   = (st_q == ST_HEAD || st_q == ST_DATA) && ro_ready && last_word;
    end

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (train_start)
                    st_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (train_start)
                    st_d = ST_ACTIVE;
                else if (take_trig)
                    st_d = ST_WAIT;
                else if (train_end)
                    st_d = ST_HEAD;
            end
            ST_WAIT: begin
                if (smp_valid)
                    st_d = (end_pend_q || train_end) ? ST_HEAD : ST_ACTIVE;
            end
            ST_HEAD: begin
                if (ro_ready)
                    st_d = (count == '0) ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (ro_done)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and per-train context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            ovf_q      <= 1'b0;
            end_pend_q <= 1'b0;
            ts_hold_q  <= '0;
            idx_q      <= '0;
        end else begin
            st_q <= st_d;
            if (start_ok || ro_done)
                ovf_q <= 1'b0;
            else if (drop_trig)
                ovf_q <= 1'b1;
            if (take_trig)
                end_pend_q <= train_end;
            else if (st_q == ST_WAIT) begin
                if (wr_now)
                    end_pend_q <= 1'b0;
                else if (train_end)
                    end_pend_q <= 1'b1;
            end
            if (take_trig)
                ts_hold_q <= ts;
            if (st_q == ST_HEAD)
                idx_q <= '0;
            else if (st_q == ST_DATA && ro_ready)
                idx_q <= idx_q + IDX_W'(1);
        end
    end

    // outputs
    always_comb begin
        smp_ready = 1'b0;
        ro_valid  = 1'b0;
        ro_data   = '0;
        ro_last   = 1'b0;
        unique case (st_q)
            ST_WAIT: smp_ready = 1'b1;
            ST_HEAD: begin
                ro_valid = 1'b1;
                ro_data  = WORD_W'({ovf_q, count});
                ro_last  = last_word;
            end
            ST_DATA: begin
                ro_valid = 1'b1;
                ro_data  = rd_data;
                ro_last  = last_word;
            end
            default: ;
        endcase
        slot_clr   = start_ok || ro_done;
        slot_wr    = wr_now;
        slot_wdata = {ts_hold_q, smp_range, smp_amp};
        rd_idx     = idx_q;
        ts_clr     = start_ok;
        ts_run     = (st_q == ST_ACTIVE) || (st_q == ST_WAIT);
    end

    // R9
    ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_valid && !ro_ready) |=> (ro_valid && $stable(ro_data)));

    // R8
    ro_cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ro_valid && !ro_ready) |=> $stable(count));

    // R6
    ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> $past(full));

    // R11
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ro_done |=> (count == '0));

    // R10
    no_ro_while_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |-> !ro_valid);
endmodule

// File: rtl/train_event_buffer.sv
module train_event_buffer
    import tebuf_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int AMP_W = 13,
    parameter int TS_W  = 13
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig_mode,
    input  logic                      self_hit,
    input  logic                      ext_trig,
    input  logic                      train_start,
    input  logic                      train_end,
    input  logic                      smp_valid,
    output logic                      smp_ready,
    input  logic [AMP_W-1:0]          smp_amp,
    input  logic                      smp_range,
    output logic                      ro_valid,
    input  logic                      ro_ready,
    output logic [TS_W+AMP_W:0]       ro_data,
    output logic                      ro_last
);
    localparam int CNT_W  = $clog2(SLOTS + 1);
    localparam int IDX_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int WORD_W = TS_W + 1 + AMP_W;

    logic              trig;
    logic [TS_W-1:0]   ts;
    logic [CNT_W-1:0]  count;
    logic              full;
    logic [WORD_W-1:0] rd_data, slot_wdata;
    logic [IDX_W-1:0]  rd_idx;
    logic              slot_clr, slot_wr, ts_clr, ts_run;

    assign trig = trig_mode ? ext_trig : self_hit;

    tebuf_tstamp #(.TS_W(TS_W)) u_ts (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ts_clr),
        .run   (ts_run),
        .ts    (ts)
    );

    tebuf_slots #(
        .SLOTS(SLOTS), .WORD_W(WORD_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (slot_clr),
        .wr_en   (slot_wr),
        .wr_data (slot_wdata),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .count   (count),
        .full    (full)
    );

    tebuf_ctrl #(
        .SLOTS(SLOTS), .TS_W(TS_W), .AMP_W(AMP_W),
        .CNT_W(CNT_W), .IDX_W(IDX_W), .WORD_W(WORD_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .train_start (train_start),
        .train_end   (train_end),
        .trig        (trig),
        .smp_valid   (smp_valid),
        .smp_amp     (smp_amp),
        .smp_range   (smp_range),
        .ro_ready    (ro_ready),
        .ts          (ts),
        .count       (count),
        .full        (full),
        .rd_data     (rd_data),
        .smp_ready   (smp_ready),
        .ro_valid    (ro_valid),
        .ro_data     (ro_data),
        .ro_last     (ro_last),
        .slot_clr    (slot_clr),
        .slot_wr     (slot_wr),
        .slot_wdata  (slot_wdata),
        .rd_idx      (rd_idx),
        .ts_clr      (ts_clr),
        .ts_run      (ts_run)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!ro_valid && !smp_ready));
endmodule

// File: tb/train_event_buffer_tb_top.sv
`timescale 1ns/100ps
module train_event_buffer_tb_top;
    localparam int WORD_W = 27;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_mode = 1'b0, self_hit = 1'b0, ext_trig = 1'b0;
    logic              train_start = 1'b0, train_end = 1'b0;
    logic              smp_valid = 1'b0, smp_range = 1'b0;
    logic [12:0]       smp_amp = '0;
    logic              smp_ready, ro_valid, ro_last;
    logic              ro_ready = 1'b1;
    logic [WORD_W-1:0] ro_data;

    int checks = 0, errors = 0, cyc = 0, t0 = 0;
    bit slow_rd = 1'b0, done = 1'b0;
    logic [WORD_W:0]   expq [$];
    logic [WORD_W-1:0] mslot [$];
    bit movf = 1'b0;
    bit stall_prev = 1'b0;
    logic [WORD_W-1:0] prev_data = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) ro_ready <= slow_rd ? ((cyc % 3) != 1) : 1'b1;

    train_event_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .self_hit(self_hit),
        .ext_trig(ext_trig), .train_start(train_start), .train_end(train_end),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_amp(smp_amp),
        .smp_range(smp_range), .ro_valid(ro_valid), .ro_ready(ro_ready),
        .ro_data(ro_data), .ro_last(ro_last)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // scoreboard driver: queue header and events of the finished train
    task automatic push_expect();
        int n = mslot.size();
        expq.push_back({(n == 0), WORD_W'({movf, 3'(n)})});
        for (int i = 0; i < n; i++)
            expq.push_back({(i == n - 1), mslot[i]});
    endtask

    task automatic start_train();
        @(negedge clk); train_start = 1'b1;
        @(negedge clk); train_start = 1'b0;
        t0 = cyc; mslot.delete(); movf = 1'b0;
    endtask

    task automatic pulse_trig(input bit v);
        if (trig_mode) ext_trig = v; else self_hit = v;
    endtask

    task automatic fire(input logic [12:0] amp, input bit rng, input int gap,
                        input bit stray, input bit with_end);
        logic [12:0] tsx;
        bit store;
        @(negedge clk);
        pulse_trig(1'b1);
        if (with_end) train_end = 1'b1;
        tsx = 13'(cyc - t0);
        store = (mslot.size() < 4);
        @(negedge clk);
        pulse_trig(1'b0); train_end = 1'b0;
        if (store) begin
            chk(smp_ready == 1'b1, "R4 ready after trigger", 32'(smp_ready), 32'd1);
            for (int i = 0; i < gap; i++) begin
                if (with_end) chk(ro_valid == 1'b0, "R10 readout held while sample pending", 32'(ro_valid), 32'd0);
                pulse_trig(stray && i == 0);
                @(negedge clk);
            end
            pulse_trig(1'b0);
            smp_valid = 1'b1; smp_amp = amp; smp_range = rng;
            @(negedge clk);
            smp_valid = 1'b0;
            chk(smp_ready == 1'b0, "R4 ready drops after sample", 32'(smp_ready), 32'd0);
            mslot.push_back({tsx, rng, amp});
        end else begin
            movf = 1'b1;
            chk(smp_ready == 1'b0, "R6 trigger when full not taken", 32'(smp_ready), 32'd0);
        end
        if (with_end) push_expect();
    endtask

    task automatic end_train();
        @(negedge clk); train_end = 1'b1;
        @(negedge clk); train_end = 1'b0;
        push_expect();
    endtask

    task automatic drain();
        wait (expq.size() == 0);
        repeat (3) @(negedge clk);
        chk(ro_valid == 1'b0, "R11 idle after final word", 32'(ro_valid), 32'd0);
    endtask

    // monitor: compare accepted words against the scoreboard queue
    always begin
        logic [WORD_W:0] e;
        @(negedge clk); #1;
        if (rst_n) begin
            if (stall_prev)
                chk(ro_valid && ro_data == prev_data, "R9 word held under stall", 32'(ro_data), 32'(prev_data));
            stall_prev = ro_valid && !ro_ready;
            prev_data  = ro_data;
            if (ro_valid && ro_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R8 unexpected readout word", 32'(ro_data), 32'd0);
                end else begin
                    e = expq.pop_front();
                    // R4 R7 R8: amplitude, range, timestamp, order, last flag
                    chk({ro_last, ro_data} == e, "R8 readout word", 32'({ro_last, ro_data}), 32'(e));
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ro_valid == 1'b0, "R1 ro_valid after reset", 32'(ro_valid), 32'd0);
        chk(smp_ready == 1'b0, "R1 smp_ready after reset", 32'(smp_ready), 32'd0);
        chk(ro_last == 1'b0, "R1 ro_last after reset", 32'(ro_last), 32'd0);

        // train A: self-trigger mode, external input must be ignored (R3)
        trig_mode = 1'b0;
        start_train();
        fire(13'h0123, 1'b0, 0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        chk(smp_ready == 1'b0, "R3 unselected trigger ignored", 32'(smp_ready), 32'd0);
        fire(13'h1FFF, 1'b1, 2, 1'b0, 1'b0);
        end_train();
        drain();

        // train B: external mode, overflow, stray trigger, stalled readout
        trig_mode = 1'b1;
        self_hit = 1'b1;
        start_train();
        self_hit = 1'b0;
        chk(smp_ready == 1'b0, "R3 self-trigger ignored in external mode", 32'(smp_ready), 32'd0);
        fire(13'h0001, 1'b0, 1, 1'b0, 1'b0);
        fire(13'h0AAA, 1'b1, 3, 1'b1, 1'b0);   // R5 stray trigger while waiting
        fire(13'h1555, 1'b0, 0, 1'b0, 1'b0);
        fire(13'h0F0F, 1'b1, 2, 1'b0, 1'b0);
        fire(13'h1234, 1'b0, 0, 1'b0, 1'b0);   // R6 fifth trigger overflows
        slow_rd = 1'b1;
        end_train();
        @(negedge clk);
        train_start = 1'b1; ext_trig = 1'b1;   // R2 R5 during readout
        @(negedge clk);
        train_start = 1'b0; ext_trig = 1'b0;
        chk(smp_ready == 1'b0, "R5 trigger during readout discarded", 32'(smp_ready), 32'd0);
        drain();
        slow_rd = 1'b0;

        // idle: trigger and train_end ignored
        @(negedge clk); ext_trig = 1'b1;
        @(negedge clk); ext_trig = 1'b0;
        chk(smp_ready == 1'b0, "R5 trigger while idle discarded", 32'(smp_ready), 32'd0);
        @(negedge clk); train_end = 1'b1;
        @(negedge clk); train_end = 1'b0;
        @(negedge clk);
        chk(ro_valid == 1'b0, "R11 train_end while idle ignored", 32'(ro_valid), 32'd0);

        // train D: empty, header must show count 0 and cleared overflow (R2)
        start_train();
        end_train();
        drain();

        // train C: trigger and train_end in one cycle (R10)
        start_train();
        fire(13'h0777, 1'b1, 1, 1'b0, 1'b0);
        fire(13'h0ABC, 1'b0, 4, 1'b0, 1'b1);
        drain();

        // train E: timestamp wraps past 8191 (R7)
        start_train();
        repeat (8200) @(negedge clk);
        fire(13'h0042, 1'b1, 1, 1'b0, 1'b0);
        end_train();
        drain();

        chk(expq.size() == 0, "R8 all expected words seen", 32'(expq.size()), 32'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule